// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block is a word-addressed general-purpose I/O controller for a parameterised number of pins, up to 128 (typical builds use 20, 35 or 80). Every pin owns a configuration word. That word holds the level the pin drives out and a read-only copy of the pin's synchronised input. It also holds an invert bit and a two-bit field that chooses how input activity becomes an event: a held level, a rising transition, or any transition.

Events latch into status words that hold 32 pins each, and software acknowledges them by writing ones. Enable words with the same 32-pin grouping decide which latched events reach the single interrupt line. Software reaches every word through a plain 32-bit write/read port: a write takes effect at the clock edge, and read data appears one cycle after the read strobe.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset, every enable bit, status bit, drive bit, invert bit and event field is zero, so `pin_out` is all zeros and `irq` is low.
- R2: Pin n's configuration word is at byte address 0x600 + 16*n. A write there sets bit 0 (drive), bit 23 (invert) and bits 26:25 (event field), and bit 0 appears on `pin_out[n]` on the clock edge of the write.
- R3: Bit 1 of pin n's configuration word reads the value of `pin_in[n]` after a two-flop synchroniser. Writes to bit 1 are ignored and the other bits of the word read as zero.
- R4: When bit 23 is set, the synchronised input is inverted before event detection, so a low pin counts as active.
- R5: Event field 00, and likewise 10, is level mode: the status bit is set on every cycle in which the (possibly inverted) input is high.
- R6: Event field 01 sets the status bit only on a 0-to-1 transition of the (possibly inverted) input. A held high level or a falling transition does not set it again.
- R7: Event field 11 sets the status bit on both rising and falling transitions of the (possibly inverted) input.
- R8: Status for pin n is bit n%32 of the word at 0x100 + 4*(n/32). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When a detected event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R10: Enable for pin n is bit n%32 of the read/write word at 0x110 + 4*(n/32). `irq` is high exactly when some status bit and its matching enable bit are both set.
- R11: Status and enable bits of pins at or beyond NUM_PINS read as zero and cannot be written. Configuration addresses of such pins read as zero and a write to them changes no output.
- R12: `rdata` loads the addressed word on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe; data appears on `rdata` one cycle later |
| addr | input | ADDR_W | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Pin output levels (drive bits) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest condition to reach is the collision of a hardware set and a software clear on one status bit. The stimulus holds a pin high in level mode, so a fresh event is detected on every cycle, and then writes a one to its status bit. The bit must read back as set, and it clears only once the pin has dropped. The edge modes need the converse condition, a held level with no new event after an acknowledge. The bench produces it by clearing the bit while the input stays high and checking that the bit does not return.

// File: rtl/gpio_ev_pkg.sv
package gpio_ev_pkg;

   localparam int WORD_W      = 32;
   localparam int CFG_BASE    = 'h600;
   localparam int CFG_STRIDE  = 16;
   localparam int STS_BASE    = 'h100;
   localparam int ENA_BASE    = 'h110;
   localparam int BANK_STRIDE = 4;

   localparam int B_DRIVE   = 0;
   localparam int B_SENSE   = 1;
   localparam int B_INVERT  = 23;
   localparam int B_MODE_LO = 25;
   localparam int B_MODE_HI = 26;

   typedef enum logic [1:0] {
      EV_LEVEL     = 2'b00,
      EV_RISE      = 2'b01,
      EV_LEVEL_ALT = 2'b10,
      EV_BOTH      = 2'b11
   } ev_mode_e;

   typedef struct packed {
      logic     drive;
      logic     invert;
      ev_mode_e mode;
   } pin_cfg_t;

endpackage

// File: rtl/gpio_ev_sync.sv
module gpio_ev_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ev_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_ev_pin.sv
module gpio_ev_pin
   import gpio_ev_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pin_sync,
   output logic              drive,
   output logic [WORD_W-1:0] cfg_rd,
   output logic              ev_hit
);

   pin_cfg_t cfg_q;
   logic     seen_q;
   logic     cooked;

   assign cooked = pin_sync ^ cfg_q.invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (cfg_we) begin
            cfg_q.drive  <= wdata[B_DRIVE];
            cfg_q.invert <= wdata[B_INVERT];
            cfg_q.mode   <= ev_mode_e'(wdata[B_MODE_HI:B_MODE_LO]);
         end
         seen_q <= cooked;
      end
   end

   always_comb begin
      unique case (cfg_q.mode)
         EV_RISE:      ev_hit = cooked & ~seen_q;
         EV_BOTH:      ev_hit = cooked ^ seen_q;
         EV_LEVEL,
         EV_LEVEL_ALT: ev_hit = cooked;
         default:      ev_hit = cooked;
      endcase
   end

   always_comb begin
      cfg_rd                      = '0;
      cfg_rd[B_DRIVE]             = cfg_q.drive;
      cfg_rd[B_SENSE]             = pin_sync;
      cfg_rd[B_INVERT]            = cfg_q.invert;
      cfg_rd[B_MODE_HI:B_MODE_LO] = cfg_q.mode;
   end

   assign drive = cfg_q.drive;

endmodule

// File: rtl/gpio_ev_bank.sv
module gpio_ev_bank
   import gpio_ev_pkg::*;
#(
   parameter logic [WORD_W-1:0] LIVE_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sts_we,
   input  logic              ena_we,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] hit,
   output logic [WORD_W-1:0] sts,
   output logic [WORD_W-1:0] ena
);

   logic [WORD_W-1:0] sts_q, ena_q, clr;

   assign clr = sts_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         ena_q <= '0;
      end else begin
         // a fresh event overrides a clear in the same cycle
         sts_q <= ((sts_q & ~clr) | hit) & LIVE_MASK;
         if (ena_we) ena_q <= wdata & LIVE_MASK;
      end
   end

   assign sts = sts_q;
   assign ena = ena_q;

endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
   import gpio_ev_pkg::*;
#(
   parameter int NUM_PINS    = 80,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [WORD_W-1:0]   wdata,
   output logic [WORD_W-1:0]   rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic                irq
);

   localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int BANK_BITS = NUM_BANKS * WORD_W;
   localparam int CFG_LAST  = CFG_BASE + CFG_STRIDE * (NUM_PINS - 1);

   if (NUM_PINS < 1 || NUM_PINS > 128) begin : g_bad_pins
      $error("gpio_event_ctrl: NUM_PINS must lie in 1..128");
   end
   if (CFG_LAST >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_event_ctrl: ADDR_W too narrow for the pin count");
   end

   logic [NUM_PINS-1:0]  pin_sync;
   logic [NUM_PINS-1:0]  hit;
   logic [NUM_PINS-1:0]  cfg_we;
   logic [WORD_W-1:0]    cfg_rd [NUM_PINS];
   logic [BANK_BITS-1:0] hit_pad;
   logic [BANK_BITS-1:0] sts_flat;
   logic [BANK_BITS-1:0] en_flat;
   logic [WORD_W-1:0]    rd_word;
   logic [WORD_W-1:0]    rdata_q;

   gpio_ev_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + CFG_STRIDE * p);
      assign cfg_we[p] = wr_en && (addr == MY_ADDR);

      gpio_ev_pin i_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we[p]),
         .wdata    (wdata),
         .pin_sync (pin_sync[p]),
         .drive    (pin_out[p]),
         .cfg_rd   (cfg_rd[p]),
         .ev_hit   (hit[p])
      );
   end

   always_comb begin
      hit_pad               = '0;
      hit_pad[NUM_PINS-1:0] = hit;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LIVE = (NUM_PINS - WORD_W * b) >= WORD_W ? WORD_W
                                                               : (NUM_PINS - WORD_W * b);
      localparam logic [WORD_W-1:0] MASK = (LIVE == WORD_W) ? {WORD_W{1'b1}}
                                                            : ((WORD_W'(1) << LIVE) - WORD_W'(1));
      localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(STS_BASE + BANK_STRIDE * b);
      localparam logic [ADDR_W-1:0] E_ADDR = ADDR_W'(ENA_BASE + BANK_STRIDE * b);

      gpio_ev_bank #(
         .LIVE_MASK (MASK)
      ) i_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .sts_we (wr_en && (addr == S_ADDR)),
         .ena_we (wr_en && (addr == E_ADDR)),
         .wdata  (wdata),
         .hit    (hit_pad[b*WORD_W +: WORD_W]),
         .sts    (sts_flat[b*WORD_W +: WORD_W]),
         .ena    (en_flat[b*WORD_W +: WORD_W])
      );
   end

   always_comb begin
      rd_word = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == ADDR_W'(STS_BASE + BANK_STRIDE * b)) rd_word = sts_flat[b*WORD_W +: WORD_W];
         if (addr == ADDR_W'(ENA_BASE + BANK_STRIDE * b)) rd_word = en_flat[b*WORD_W +: WORD_W];
      end
      for (int p = 0; p < NUM_PINS; p++) begin
         if (addr == ADDR_W'(CFG_BASE + CFG_STRIDE * p)) rd_word = cfg_rd[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_word;
   end

   assign rdata = rdata_q;
   assign irq   = |(sts_flat & en_flat);

endmodule

// File: rtl/gpio_ev_chk.sv
module gpio_ev_chk
   import gpio_ev_pkg::*;
#(
   parameter int NUM_PINS = 80,
   parameter int ADDR_W   = 12
) (
   input logic                                              clk,
   input logic                                              rst_n,
   input logic                                              wr_en,
   input logic                                              rd_en,
   input logic [ADDR_W-1:0]                                 addr,
   input logic [WORD_W-1:0]                                 wdata,
   input logic [WORD_W-1:0]                                 rdata,
   input logic [NUM_PINS-1:0]                               pin_out,
   input logic                                              irq,
   input logic [((NUM_PINS + WORD_W - 1) / WORD_W)*WORD_W-1:0] sts_flat,
   input logic [((NUM_PINS + WORD_W - 1) / WORD_W)*WORD_W-1:0] en_flat
);

   localparam logic [ADDR_W-1:0] CFG0 = ADDR_W'(CFG_BASE);
   localparam logic [ADDR_W-1:0] STS0 = ADDR_W'(STS_BASE);
   localparam logic [ADDR_W-1:0] ENA0 = ADDR_W'(ENA_BASE);

   // R2
   drive_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CFG0) |=> (pin_out[0] == $past(wdata[B_DRIVE])));

   // R8
   status_no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == STS0) |=> (($past(sts_flat[WORD_W-1:0]) & ~sts_flat[WORD_W-1:0]) == '0));

   // R10
   enable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ENA0) |=> $stable(en_flat[WORD_W-1:0]));

   // R10
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat == '0) |-> !irq);

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

bind gpio_event_ctrl gpio_ev_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) i_gpio_ev_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .pin_out  (pin_out),
   .irq      (irq),
   .sts_flat (sts_flat),
   .en_flat  (en_flat)
);

// File: tb/test_gpio_event_ctrl.sv
module test_gpio_event_ctrl;

   localparam int NP = 80;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   gpio_event_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_event_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
   );

   function automatic logic [AW-1:0] cfg_a(input int p);
      return AW'(12'h600 + 16 * p);
   endfunction
   function automatic logic [AW-1:0] sts_a(input int b);
      return AW'(12'h100 + 4 * b);
   endfunction
   function automatic logic [AW-1:0] ena_a(input int b);
      return AW'(12'h110 + 4 * b);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 pin_out", 32'(pin_out != '0), 32'd0);
      check("R1 irq", 32'(irq), 32'd0);
      rd(sts_a(0), d); check("R1 status0", d, 32'd0);
      rd(ena_a(1), d); check("R1 enable1", d, 32'd0);
      rd(cfg_a(0), d); check("R1 cfg0", d, 32'd0);
   endtask

   task automatic t_config_word();
      logic [31:0] d;
      wr(cfg_a(5), 32'h0000_0001);
      check("R2 pin_out[5]", 32'(pin_out), 32'h0000_0020);
      wr(cfg_a(5), 32'h0);
      check("R2 pin_out[5] low", 32'(pin_out[5]), 32'd0);
      // every writable field plus junk bits: invert on, both-edge mode, drive on
      wr(cfg_a(20), 32'hFFFF_FFFF);
      rd(cfg_a(20), d);
      check("R2 R3 cfg20 fields", d, 32'h0680_0001);
      wr(cfg_a(20), 32'h0);
      settle();
      wr(sts_a(0), 32'hFFFF_FFFF);
      rd(sts_a(0), d); check("R8 status0 cleared", d, 32'd0);
   endtask

   task automatic t_input_sense();
      logic [31:0] d;
      wr(cfg_a(7), 32'h0000_0002);
      rd(cfg_a(7), d); check("R3 sense ignores write", d, 32'd0);
      check("R3 pin_out[7]", 32'(pin_out[7]), 32'd0);
      @(negedge clk); pin_in[7] = 1'b1;
      settle();
      rd(cfg_a(7), d); check("R3 sense high", d, 32'h0000_0002);
      @(negedge clk); pin_in[7] = 1'b0;
      settle();
      wr(sts_a(0), 32'hFFFF_FFFF);
      rd(cfg_a(7), d); check("R3 sense low", d, 32'd0);
   endtask

   task automatic t_level_and_collision();
      logic [31:0] d;
      wr(ena_a(0), 32'h0000_0008);
      @(negedge clk); pin_in[3] = 1'b1;
      settle();
      rd(sts_a(0), d); check("R5 level sets", d, 32'h0000_0008);
      check("R10 irq", 32'(irq), 32'd1);
      wr(sts_a(0), 32'h0000_0008);
      rd(sts_a(0), d); check("R9 set wins over clear", d, 32'h0000_0008);
      @(negedge clk); pin_in[3] = 1'b0;
      settle();
      wr(sts_a(0), 32'h0000_0008);
      rd(sts_a(0), d); check("R8 cleared after drop", d, 32'd0);
      check("R10 irq low", 32'(irq), 32'd0);
      wr(ena_a(0), 32'h0);
      // event field 10 behaves as level
      wr(cfg_a(12), 32'h0400_0000);
      @(negedge clk); pin_in[12] = 1'b1;
      settle();
      wr(sts_a(0), 32'h0000_1000);
      rd(sts_a(0), d); check("R5 mode 10 level", d, 32'h0000_1000);
      @(negedge clk); pin_in[12] = 1'b0;
      settle();
      wr(sts_a(0), 32'h0000_1000);
      wr(cfg_a(12), 32'h0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(cfg_a(40), 32'h0200_0000);
      @(negedge clk); pin_in[40] = 1'b1;
      settle();
      rd(sts_a(1), d); check("R6 rising sets", d, 32'h0000_0100);
      wr(sts_a(1), 32'h0000_0100);
      settle();
      rd(sts_a(1), d); check("R6 held high no reset", d, 32'd0);
      @(negedge clk); pin_in[40] = 1'b0;
      settle();
      rd(sts_a(1), d); check("R6 falling ignored", d, 32'd0);
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr(cfg_a(33), 32'h0600_0000);
      @(negedge clk); pin_in[33] = 1'b1;
      settle();
      rd(sts_a(1), d); check("R7 rise sets", d, 32'h0000_0002);
      wr(sts_a(1), 32'h0000_0002);
      @(negedge clk); pin_in[33] = 1'b0;
      settle();
      rd(sts_a(1), d); check("R7 fall sets", d, 32'h0000_0002);
      wr(sts_a(1), 32'h0000_0002);
      wr(cfg_a(33), 32'h0);
   endtask

   task automatic t_invert();
      logic [31:0] d;
      wr(cfg_a(10), 32'h0080_0000);
      settle();
      rd(sts_a(0), d); check("R4 low pin active", d, 32'h0000_0400);
      @(negedge clk); pin_in[10] = 1'b1;
      settle();
      wr(sts_a(0), 32'h0000_0400);
      rd(sts_a(0), d); check("R4 high pin inactive", d, 32'd0);
      wr(cfg_a(10), 32'h0);
      settle();
      wr(sts_a(0), 32'hFFFF_FFFF);
      @(negedge clk); pin_in[10] = 1'b0;
   endtask

   task automatic t_gate_and_w0();
      logic [31:0] d;
      wr(cfg_a(79), 32'h0200_0000);
      @(negedge clk); pin_in[79] = 1'b1;
      settle();
      check("R10 masked no irq", 32'(irq), 32'd0);
      wr(ena_a(2), 32'h0000_8000);
      check("R10 enabled irq", 32'(irq), 32'd1);
      wr(sts_a(2), 32'h0);
      rd(sts_a(2), d); check("R8 write zero keeps", d, 32'h0000_8000);
      wr(sts_a(2), 32'h0000_8000);
      rd(sts_a(2), d); check("R8 write one clears", d, 32'd0);
      check("R10 irq drops", 32'(irq), 32'd0);
      @(negedge clk); pin_in[79] = 1'b0;
      wr(cfg_a(79), 32'h0);
   endtask

   task automatic t_absent();
      logic [31:0] d;
      wr(ena_a(2), 32'hFFFF_FFFF);
      rd(ena_a(2), d); check("R11 enable2 masked", d, 32'h0000_FFFF);
      wr(ena_a(2), 32'h0);
      wr(cfg_a(80), 32'h0000_0001);
      check("R11 no pin change", 32'(pin_out != '0), 32'd0);
      rd(cfg_a(80), d); check("R11 absent cfg", d, 32'd0);
   endtask

   task automatic t_read_hold();
      logic [31:0] d;
      wr(ena_a(0), 32'h0000_00A5);
      rd(ena_a(0), d);
      @(negedge clk); addr = sts_a(0);
      @(negedge clk);
      check("R12 rdata held", rdata, 32'h0000_00A5);
      wr(ena_a(0), 32'h0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config_word();
      t_input_sense();
      t_level_and_collision();
      t_rise();
      t_both();
      t_invert();
      t_gate_and_w0();
      t_absent();
      t_read_hold();
      finish_run();
   end

endmodule